// File: doc/BRIEF.md
# Two-Dimensional Priority Interrupt Controller

This block gathers up to 63 interrupt request lines from peripherals and presents a single winner to a processor core. The winner is reported as an encoded request level from 1 to 7, with 0 meaning that nothing is pending, and as an 8-bit vector number that is unique to each source. Arbitration works in two steps. A source's level is compared first. Among sources at the same level, a second field called the in-level priority decides. If both fields are equal, the source with the lower index wins.

Sources 0 to 55 take their level and priority from software through a small write port. The top seven sources have constant settings that software cannot change. Each source has its own mask bit, and one global bit silences all of them. The result is recomputed and registered on every clock edge. An acknowledge strobe captures the vector of the current winner for the core. The acknowledge does not clear the request; the peripheral must remove it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_level` is 0, `irq_vector` is 24, `ack_valid` is 0, every programmable source has level 0 and priority 0, all per-source masks are clear and the global mask is clear.
- R2: Source i is reported with vector 64+i. When no source is eligible, `irq_level` is 0 and the vector is the spurious value 24.
- R3: A write with `cfg_op`=0 to index 0..55 sets that source's level from `cfg_wdata[5:3]` and its priority from `cfg_wdata[2:0]`.
- R4: Source 56+k (k = 0..6) has a fixed level k+1 and a fixed priority 7. Writes with `cfg_op`=0 to indices 56..63 have no effect.
- R5: A source whose level is 0 never wins, even if it is requesting and unmasked.
- R6: Among eligible sources, the highest level wins. Within that level the highest priority wins. If both are equal, the lowest index wins.
- R7: A write with `cfg_op`=1 sets the mask bit of source `cfg_idx` to `cfg_wdata[0]`. A masked source is not eligible.
- R8: A write with `cfg_op`=2 sets the global mask to `cfg_wdata[0]`. While the global mask is set, `irq_level` is 0 and the vector is 24.
- R9: `irq_level` and `irq_vector` reflect the requests and settings sampled at the previous clock edge, which is a latency of one edge.
- R10: When `iack` is sampled high, the next edge raises `ack_valid` for one cycle and loads `ack_vector` with the `irq_vector` that was shown during the acknowledge cycle. The acknowledge leaves the request pending.
- R11: A write with `cfg_op`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 63 | Request lines, one per source, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Write kind: 0 level/priority, 1 source mask, 2 global mask, 3 no-op |
| cfg_idx | input | 6 | Source index for kinds 0 and 1 |
| cfg_wdata | input | 6 | Write data: [5:3] level, [2:0] priority, [0] mask value |
| iack | input | 1 | Interrupt acknowledge strobe from the core |
| irq_level | output | 3 | Level of the current winner, 0 when none |
| irq_vector | output | 8 | Vector of the current winner, or 24 |
| ack_valid | output | 1 | One-cycle pulse after an acknowledge |
| ack_vector | output | 8 | Vector captured by the last acknowledge |

## Verification
Two things can happen on the same clock edge: a configuration write or a request change, and an acknowledge. In that case the captured vector must be the winner that was shown before the edge, while the level and vector outputs move to the new winner. The bench provokes this by issuing `iack` together with mask, level and request changes, both in directed steps and in a long random phase. A behavioural model keeps its own tables and checks the captured vector against the outgoing winner and the outputs against the new one on every cycle.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  typedef enum logic [1:0] {
    OP_LVLPRI = 2'd0,
    OP_MASK   = 2'd1,
    OP_GMASK  = 2'd2,
    OP_NONE   = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/prio_irq_cfg.sv
`timescale 1ns/1ps
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int LVL_W     = 3,
  parameter int PRI_W     = 3,
  parameter int IDX_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  cfg_op_e                          cfg_op,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [LVL_W+PRI_W-1:0]           cfg_wdata,
  output logic [NUM_SRC-1:0][LVL_W-1:0]    src_lvl,
  output logic [NUM_SRC-1:0][PRI_W-1:0]    src_pri,
  output logic [NUM_SRC-1:0]               src_mask,
  output logic                             glob_mask
);
  localparam int NUM_PROG = NUM_SRC - NUM_FIXED;
  localparam int LVL_MAX  = (1 << LVL_W) - 1;
  localparam int PRI_MAX  = (1 << PRI_W) - 1;

  logic lp_wr, mask_wr, gmask_wr;
  logic gmask_q, gmask_d;

  always_comb begin
    lp_wr    = cfg_we && (cfg_op == OP_LVLPRI);
    mask_wr  = cfg_we && (cfg_op == OP_MASK);
    gmask_wr = cfg_we && (cfg_op == OP_GMASK);
  end

  // global mask register
  always_comb gmask_d = gmask_wr ? cfg_wdata[0] : gmask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gmask_q <= 1'b0;
    else        gmask_q <= gmask_d;
  end

  assign glob_mask = gmask_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic sel;
    logic msk_q, msk_d;

    always_comb sel = (cfg_idx == IDX_W'(g));
    always_comb msk_d = (mask_wr && sel) ? cfg_wdata[0] : msk_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msk_q <= 1'b0;
      else        msk_q <= msk_d;
    end
    assign src_mask[g] = msk_q;

    if (g < NUM_PROG) begin : g_prog
      logic             en;
      logic [LVL_W-1:0] lvl_q, lvl_d;
      logic [PRI_W-1:0] pri_q, pri_d;

      always_comb begin
        en    = lp_wr && sel;
        lvl_d = lvl_q;
        pri_d = pri_q;
        if (en) begin
          lvl_d = cfg_wdata[LVL_W+PRI_W-1:PRI_W];
          pri_d = cfg_wdata[PRI_W-1:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_q <= '0;
          pri_q <= '0;
        end else if (en) begin
          lvl_q <= lvl_d;
          pri_q <= pri_d;
        end
      end

      assign src_lvl[g] = lvl_q;
      assign src_pri[g] = pri_q;
    end else begin : g_fixed
      // hard-wired: level rises with position, top priority
      assign src_lvl[g] = LVL_W'(((g - NUM_PROG) % LVL_MAX) + 1);
      assign src_pri[g] = PRI_W'(PRI_MAX);
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
`timescale 1ns/1ps
module prio_irq_arb #(
  parameter int NUM_SRC  = 63,
  parameter int LVL_W    = 3,
  parameter int PRI_W    = 3,
  parameter int IDX_W    = 6,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            irq_req,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] src_pri,
  input  logic [NUM_SRC-1:0]            src_mask,
  input  logic                          glob_mask,
  output logic [LVL_W-1:0]              win_level,
  output logic [VEC_W-1:0]              win_vector
);
  localparam int KEY_W = LVL_W + PRI_W;
  localparam int N2    = 1 << IDX_W;

  logic [N2-1:0]            leaf_v;
  logic [N2-1:0][KEY_W-1:0] leaf_k;

  for (genvar g = 0; g < N2; g++) begin : g_leaf
    if (g < NUM_SRC) begin : g_real
      assign leaf_v[g] = irq_req[g] && !src_mask[g] && !glob_mask && (src_lvl[g] != '0);
      assign leaf_k[g] = {src_lvl[g], src_pri[g]};
    end else begin : g_pad
      assign leaf_v[g] = 1'b0;
      assign leaf_k[g] = '0;
    end
  end

  logic                  top_v;
  logic [KEY_W-1:0]      top_k;
  logic [IDX_W-1:0]      top_x;

  // pairwise tournament, left (lower index) kept on equal keys
  always_comb begin
    logic [N2-1:0]            v;
    logic [N2-1:0][KEY_W-1:0] k;
    logic [N2-1:0][IDX_W-1:0] x;
    v = leaf_v;
    k = leaf_k;
    for (int i = 0; i < N2; i++) x[i] = IDX_W'(i);
    for (int s = 1; s < N2; s = s * 2) begin
      for (int i = 0; i < N2; i = i + 2 * s) begin
        if (v[i+s] && (!v[i] || (k[i+s] > k[i]))) begin
          v[i] = 1'b1;
          k[i] = k[i+s];
          x[i] = x[i+s];
        end
      end
    end
    top_v = v[0];
    top_k = k[0];
    top_x = x[0];
  end

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    if (top_v) begin
      lvl_d = top_k[KEY_W-1:PRI_W];
      vec_d = VEC_W'(VEC_BASE) + VEC_W'(top_x);
    end else begin
      lvl_d = '0;
      vec_d = VEC_W'(VEC_SPUR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= VEC_W'(VEC_SPUR);
    end else begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign win_level  = lvl_q;
  assign win_vector = vec_q;
endmodule

// File: rtl/prio_irq_ack.sv
`timescale 1ns/1ps
module prio_irq_ack #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack,
  input  logic [VEC_W-1:0] cur_vector,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vector
);
  logic             vld_q, vld_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    vld_d = iack;
    vec_d = iack ? cur_vector : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (iack) vec_q <= vec_d;
    end
  end

  assign ack_valid  = vld_q;
  assign ack_vector = vec_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 63,
  parameter int NUM_FIXED = 7,
  parameter int LVL_W     = 3,
  parameter int PRI_W     = 3,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 64,
  parameter int VEC_SPUR  = 24,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int CFG_W    = LVL_W + PRI_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_op,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               iack,
  output logic [LVL_W-1:0]   irq_level,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               ack_valid,
  output logic [VEC_W-1:0]   ack_vector
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [NUM_SRC-1:0][PRI_W-1:0] src_pri;
  logic [NUM_SRC-1:0]            src_mask;
  logic                          glob_mask;
  cfg_op_e                       op;

  assign op = cfg_op_e'(cfg_op);

  prio_irq_cfg #(
    .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED),
    .LVL_W(LVL_W), .PRI_W(PRI_W), .IDX_W(IDX_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_op(op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .src_lvl(src_lvl), .src_pri(src_pri), .src_mask(src_mask),
    .glob_mask(glob_mask)
  );

  prio_irq_arb #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PRI_W(PRI_W), .IDX_W(IDX_W),
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)
  ) arb_i (
    .clk(clk), .rst_n(rst_int_n),
    .irq_req(irq_req), .src_lvl(src_lvl), .src_pri(src_pri),
    .src_mask(src_mask), .glob_mask(glob_mask),
    .win_level(irq_level), .win_vector(irq_vector)
  );

  prio_irq_ack #(
    .VEC_W(VEC_W)
  ) ack_i (
    .clk(clk), .rst_n(rst_int_n),
    .iack(iack), .cur_vector(irq_vector),
    .ack_valid(ack_valid), .ack_vector(ack_vector)
  );
endmodule

// File: rtl/prio_irq_chk.sv
`timescale 1ns/1ps
module prio_irq_chk #(
  parameter int NUM_SRC  = 63,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24,
  parameter int CFG_W    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               cfg_we,
  input logic [1:0]         cfg_op,
  input logic [CFG_W-1:0]   cfg_wdata,
  input logic               iack,
  input logic [LVL_W-1:0]   irq_level,
  input logic [VEC_W-1:0]   irq_vector,
  input logic               ack_valid,
  input logic [VEC_W-1:0]   ack_vector
);
  // R2: no winner pairs with the spurious vector, a winner with a source vector
  a_r2_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) == (irq_vector == VEC_W'(VEC_SPUR)));

  a_r2_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_vector >= VEC_W'(VEC_BASE)));

  // R9: with nothing requesting, the next registered level is zero
  a_r9_quiet_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == '0) |=> (irq_level == '0));

  // R8: global mask set suppresses the level one edge after it lands
  a_r8_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_op == 2'd2 && cfg_wdata[0]) |=> ##1 (irq_level == '0));

  // R10: acknowledge pulse and captured vector
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> ack_valid);

  a_r10_ack_vector: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> (ack_vector == $past(irq_vector)));

  a_r10_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> !ack_valid);
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR), .CFG_W(CFG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
  .cfg_op(cfg_op), .cfg_wdata(cfg_wdata), .iack(iack),
  .irq_level(irq_level), .irq_vector(irq_vector),
  .ack_valid(ack_valid), .ack_vector(ack_vector)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int NS   = 63;
  localparam int NP   = 56;
  localparam int BASE = 64;
  localparam int SPUR = 24;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] irq_req;
  logic          cfg_we;
  logic [1:0]    cfg_op;
  logic [5:0]    cfg_idx;
  logic [5:0]    cfg_wdata;
  logic          iack;
  logic [2:0]    irq_level;
  logic [7:0]    irq_vector;
  logic          ack_valid;
  logic [7:0]    ack_vector;

  int n_run;
  int n_fail;
  bit done;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .iack(iack),
    .irq_level(irq_level), .irq_vector(irq_vector),
    .ack_valid(ack_valid), .ack_vector(ack_vector)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_lvl [NS];
  int  m_pri [NS];
  bit  m_msk [NS];
  bit  m_gm;
  int  e_level, e_vec, e_ackv, e_ackvec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_lvl[i] = (i < NP) ? 0 : (i - NP + 1);
        m_pri[i] = (i < NP) ? 0 : 7;
        m_msk[i] = 1'b0;
      end
      m_gm = 1'b0;
      e_level = 0; e_vec = SPUR; e_ackv = 0; e_ackvec = 0;
    end else begin
      int best, bidx;
      e_ackv = iack;
      if (iack) e_ackvec = e_vec;
      best = -1; bidx = -1;
      for (int i = 0; i < NS; i++) begin
        if (irq_req[i] && !m_msk[i] && !m_gm && m_lvl[i] != 0) begin
          if (m_lvl[i] * 8 + m_pri[i] > best) begin
            best = m_lvl[i] * 8 + m_pri[i];
            bidx = i;
          end
        end
      end
      e_level = (bidx < 0) ? 0 : m_lvl[bidx];
      e_vec   = (bidx < 0) ? SPUR : BASE + bidx;
      if (cfg_we) begin
        case (cfg_op)
          2'd0: if (cfg_idx < NP) begin
                  m_lvl[cfg_idx] = int'(cfg_wdata[5:3]);
                  m_pri[cfg_idx] = int'(cfg_wdata[2:0]);
                end
          2'd1: if (cfg_idx < NS) m_msk[cfg_idx] = cfg_wdata[0];
          2'd2: m_gm = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 level", int'(irq_level), e_level);
      check("R2 vector", int'(irq_vector), e_vec);
      check("R10 ack_valid", int'(ack_valid), e_ackv);
      check("R10 ack_vector", int'(ack_vector), e_ackvec);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] op, input int idx, input logic [5:0] d);
    cfg_we = 1'b1; cfg_op = op; cfg_idx = 6'(idx); cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_op = 2'd0; cfg_idx = '0; cfg_wdata = '0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; irq_req = '0; cfg_we = 1'b0; cfg_op = '0;
    cfg_idx = '0; cfg_wdata = '0; iack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(5);

    // R1 reset state
    check("R1 level", int'(irq_level), 0);
    check("R1 vector", int'(irq_vector), SPUR);
    check("R1 ack_valid", int'(ack_valid), 0);

    // R5 level-0 source never wins
    irq_req[3] = 1'b1;
    step(2);
    check("R5 level0 source", int'(irq_level), 0);

    // R3 program source 3: level 4 priority 2
    wr(2'd0, 3, {3'd4, 3'd2});
    step();
    check("R3 level", int'(irq_level), 4);
    check("R3 vector", int'(irq_vector), BASE + 3);

    // R6 priority inside level
    wr(2'd0, 10, {3'd4, 3'd5});
    irq_req[10] = 1'b1;
    step(2);
    check("R6 priority", int'(irq_vector), BASE + 10);
    // R6 equal level and priority: lower index
    wr(2'd0, 5, {3'd4, 3'd5});
    irq_req[5] = 1'b1;
    step(2);
    check("R6 index tie", int'(irq_vector), BASE + 5);
    // R6 higher level beats higher priority
    wr(2'd0, 20, {3'd6, 3'd0});
    irq_req[20] = 1'b1;
    step(2);
    check("R6 level wins", int'(irq_vector), BASE + 20);
    check("R6 level value", int'(irq_level), 6);

    // R7 per-source mask
    wr(2'd1, 20, 6'd1);
    step();
    check("R7 masked", int'(irq_vector), BASE + 5);
    wr(2'd1, 20, 6'd0);
    step();
    check("R7 unmasked", int'(irq_vector), BASE + 20);

    // R4 fixed source 62: level 7, and writes ignored
    irq_req[62] = 1'b1;
    step(2);
    check("R4 fixed level", int'(irq_level), 7);
    check("R4 fixed vector", int'(irq_vector), BASE + 62);
    wr(2'd0, 62, {3'd1, 3'd0});
    step();
    check("R4 write ignored", int'(irq_level), 7);
    irq_req[62] = 1'b0;
    irq_req[56] = 1'b1;
    step(2);
    check("R4 fixed 56 loses", int'(irq_vector), BASE + 20);

    // R11 op 3 changes nothing
    wr(2'd3, 20, 6'd0);
    step();
    check("R11 noop", int'(irq_vector), BASE + 20);

    // R8 global mask
    wr(2'd2, 0, 6'd1);
    step();
    check("R8 gmask level", int'(irq_level), 0);
    check("R8 gmask vector", int'(irq_vector), SPUR);
    wr(2'd2, 0, 6'd0);
    step();
    check("R8 gmask off", int'(irq_level), 6);

    // R10 acknowledge keeps request pending; ack coinciding with a mask write
    iack = 1'b1;
    wr(2'd1, 20, 6'd1);
    iack = 1'b0;
    check("R10 ack valid", int'(ack_valid), 1);
    check("R10 ack vector", int'(ack_vector), BASE + 20);
    step();
    check("R10 request kept", int'(irq_vector), BASE + 5);
    check("R10 pulse ends", int'(ack_valid), 0);

    // R9 one-edge latency, R2 spurious acknowledge
    irq_req = '0;
    step(2);
    irq_req[62] = 1'b1;
    check("R9 before edge", int'(irq_level), 0);
    step();
    check("R9 after edge", int'(irq_level), 7);
    irq_req = '0;
    step();
    iack = 1'b1;
    step();
    iack = 1'b0;
    check("R2 spurious ack", int'(ack_vector), SPUR);

    // random phase, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      irq_req = NS'(r & {$urandom(), $urandom()});
      iack = ($urandom() % 4) == 0;
      cfg_we = ($urandom() % 3) == 0;
      cfg_op = 2'($urandom());
      cfg_idx = 6'($urandom());
      cfg_wdata = 6'($urandom());
      if (cfg_op == 2'd2) cfg_wdata[0] = ($urandom() % 6) == 0;
      if (cfg_op == 2'd1) cfg_wdata[0] = ($urandom() % 3) == 0;
      step();
    end
    irq_req = '0; iack = 1'b0; cfg_we = 1'b0;
    step(3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule